// File: doc/BRIEF.md
# Prioritized Interrupt Collector

This block gathers up to 128 level-sensitive interrupt inputs and turns them into a single request line to a processor. Software turns each input on or off through its own small configuration register. Among the inputs that are both asserted and turned on, the block picks the one with the lowest number. It publishes that number in a read-only status register and raises the request line.

Service follows a three-step exchange on a 32-bit synchronous register bus. Software reads the status register. It then writes any value to the vector register, which tells the block the interrupt has been taken: the request line drops and the status number freezes. Finally it writes a 1 in bit 0 of the level-acknowledge register, which ends service. An input that is still high at that point is offered again at once.

Every writable register answers at four word addresses:

- the plain write,
- a bit-set alias,
- a bit-clear alias,
- a bit-invert alias.

A control register holds a soft-reset bit and a clock-gate bit. Both are set after reset, and software must clear them before the block does anything.

Top module: `ic_collector`

## Requirements
- R1: After reset the control register (group 0x20) reads 0xC000_0000, every source register reads 0, the request line is low and the status register reads 0x7F.
- R2: The block is stalled while control bit 31 (soft reset) or bit 30 (gate) is set. During a stall the request line is low, status reads 0x7F, and writes to source, vector and acknowledge registers are ignored. While bit 31 is set, every source register and the service state are held cleared.
- R3: Address bits [3:2] select the write alias for the control and source registers: 0 replaces the value, 1 ORs the written bits in, 2 clears the written bits, 3 inverts them. A read at any of the four addresses returns the register value.
- R4: Source n has its register at byte address 0x120 + 0x10·n. Bit 2 is the enable and bits [1:0] hold a priority field that is stored and read back. Other bits read 0, and the priority field has no effect on selection.
- R5: A source is pending only when its input is high and its enable bit is 1. Inputs whose enable is 0 never raise the request line.
- R6: While idle and not stalled, the request line is high whenever any source is pending. The status register (0x70, bits [6:0]) then reads the lowest pending source number.
- R7: While idle with nothing pending, the request line is low and status reads 0x7F.
- R8: A write to the vector register (0x00–0x0C) while idle enters the taken state. In that state the request line stays low and status stays at the number captured on the vector write until service ends.
- R9: In the taken state, a write to the level-acknowledge register (0x10–0x1C) with bit 0 set returns to idle. Such a write with bit 0 clear is ignored.
- R10: A source that is still pending when acknowledged raises the request line again in the cycle after the acknowledge write.
- R11: Writes to the status register have no effect. The vector and acknowledge registers read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 128 | Level-sensitive interrupt inputs, one per source |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Some properties are checked on every cycle:

- the request line stays quiet during a stall and in the taken state;
- it rises whenever something is pending while idle;
- the reported number always belongs to a pending source;
- the frozen status holds until acknowledge;
- the taken state is entered and left on the right writes;
- soft reset wipes the enables.

Other behaviour only the bench scenarios can show: lowest-number selection among several pending inputs, the arithmetic of each write alias, ignored writes while gated, the stored priority bits, and the reappearance of an input that is still high after acknowledge. Source 127 pending alone shows that its status value is the same as the empty code.

// File: rtl/ic_pkg.sv
package ic_pkg;
   typedef enum logic [1:0] {
      AL_PLAIN = 2'd0,
      AL_OR    = 2'd1,
      AL_CLR   = 2'd2,
      AL_INV   = 2'd3
   } alias_e;

   // register groups: byte address bits [ADDR_W-1:4]
   localparam int GRP_VECTOR = 0;
   localparam int GRP_LEVACK = 1;
   localparam int GRP_CTRL   = 2;
   localparam int GRP_STAT   = 7;
   localparam int GRP_SRC0   = 18;
endpackage

// File: rtl/ic_alias_op.sv
module ic_alias_op
   import ic_pkg::*;
#(
   parameter int W = 3
) (
   input  alias_e       al,
   input  logic [W-1:0] cur,
   input  logic [W-1:0] wd,
   output logic [W-1:0] nxt
);
   always_comb begin
      case (al)
         AL_PLAIN: nxt = wd;
         AL_OR:    nxt = cur | wd;
         AL_CLR:   nxt = cur & ~wd;
         default:  nxt = cur ^ wd;
      endcase
   end
endmodule

// File: rtl/ic_src_bank.sv
module ic_src_bank
   import ic_pkg::*;
#(
   parameter int NUM_SRC     = 128,
   parameter int GRP_W       = 8,
   parameter int SYNC_STAGES = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr_all,
   input  logic                    wr_en,
   input  logic [GRP_W-1:0]        grp,
   input  alias_e                  al,
   input  logic [2:0]              wdata,
   input  logic [NUM_SRC-1:0]      src_i,
   output logic [NUM_SRC-1:0][2:0] cfg_o,
   output logic [NUM_SRC-1:0]      en_o,
   output logic [NUM_SRC-1:0]      pend_o
);
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      logic [2:0] cfg_q;
      logic [2:0] cfg_nxt;
      logic       hit;
      logic       lvl;

      assign hit = wr_en && (grp == GRP_W'(GRP_SRC0 + g));

      ic_alias_op #(.W(3)) u_op (
         .al  (al),
         .cur (cfg_q),
         .wd  (wdata),
         .nxt (cfg_nxt)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       cfg_q <= '0;
         else if (clr_all) cfg_q <= '0;
         else if (hit)     cfg_q <= cfg_nxt;
      end

      if (SYNC_STAGES == 0) begin : g_direct
         assign lvl = src_i[g];
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else begin
               sh[0] <= src_i[g];
               for (int k = 1; k < SYNC_STAGES; k++) sh[k] <= sh[k-1];
            end
         end
         assign lvl = sh[SYNC_STAGES-1];
      end

      assign cfg_o[g]  = cfg_q;
      assign en_o[g]   = cfg_q[2];
      assign pend_o[g] = lvl & cfg_q[2];
   end
endmodule

// File: rtl/ic_pick.sv
module ic_pick #(
   parameter int N    = 128,
   parameter int ID_W = 7
) (
   input  logic [N-1:0]    req,
   output logic            found,
   output logic [ID_W-1:0] id
);
   always_comb begin
      found = 1'b0;
      id    = '1;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            id    = ID_W'(i);
         end
      end
   end
endmodule

// File: rtl/ic_service.sv
module ic_service #(
   parameter int ID_W = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hold_clr,
   input  logic            blocked,
   input  logic            take_ev,
   input  logic            ack_ev,
   input  logic            live_found,
   input  logic [ID_W-1:0] live_id,
   output logic            taken_o,
   output logic [ID_W-1:0] status_o,
   output logic            irq_o
);
   localparam logic [ID_W-1:0] NONE = '1;

   logic            taken_q;
   logic [ID_W-1:0] frozen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taken_q  <= 1'b0;
         frozen_q <= NONE;
      end else if (hold_clr) begin
         taken_q  <= 1'b0;
         frozen_q <= NONE;
      end else if (!blocked) begin
         if (!taken_q && take_ev) begin
            taken_q  <= 1'b1;
            frozen_q <= live_found ? live_id : NONE;
         end else if (taken_q && ack_ev) begin
            taken_q  <= 1'b0;
         end
      end
   end

   assign taken_o  = taken_q;
   assign status_o = blocked ? NONE : (taken_q ? frozen_q : (live_found ? live_id : NONE));
   assign irq_o    = !blocked && !taken_q && live_found;
endmodule

// File: rtl/ic_collector.sv
module ic_collector
   import ic_pkg::*;
#(
   parameter int NUM_SRC     = 128,
   parameter int ADDR_W      = 12,
   parameter int SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               irq_o
);
   localparam int ID_W  = $clog2(NUM_SRC);
   localparam int GRP_W = ADDR_W - 4;

   if (NUM_SRC < 2 || ID_W > 29)
      $error("ic_collector: NUM_SRC out of range");
   if ((GRP_SRC0 + NUM_SRC) > (1 << GRP_W) || GRP_W < ID_W)
      $error("ic_collector: ADDR_W too small for the source registers");
   if (SYNC_STAGES < 0)
      $error("ic_collector: SYNC_STAGES must not be negative");

   logic [GRP_W-1:0] grp;
   alias_e           al;
   logic [1:0]       ctrl_q;
   logic [1:0]       ctrl_nxt;
   logic             srst;
   logic             blocked;
   logic             take_ev;
   logic             ack_ev;
   logic             live_found;
   logic [ID_W-1:0]  live_id;
   logic             taken;
   logic [ID_W-1:0]  status;
   logic [NUM_SRC-1:0][2:0] cfg;
   logic [NUM_SRC-1:0] en_vec;
   logic [NUM_SRC-1:0] pend;
   logic [GRP_W-1:0] rel;
   logic             unused_bus;

   assign grp     = bus_addr[ADDR_W-1:4];
   assign al      = alias_e'(bus_addr[3:2]);
   assign srst    = ctrl_q[1];
   assign blocked = |ctrl_q;
   assign take_ev = bus_we && (grp == GRP_W'(GRP_VECTOR));
   assign ack_ev  = bus_we && (grp == GRP_W'(GRP_LEVACK)) && bus_wdata[0];
   assign rel     = grp - GRP_W'(GRP_SRC0);
   assign unused_bus = ^{bus_addr[1:0], bus_wdata[29:3]};

   ic_alias_op #(.W(2)) u_ctrl_op (
      .al  (al),
      .cur (ctrl_q),
      .wd  (bus_wdata[31:30]),
      .nxt (ctrl_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= 2'b11;
      else if (bus_we && grp == GRP_W'(GRP_CTRL))
         ctrl_q <= ctrl_nxt;
   end

   ic_src_bank #(
      .NUM_SRC     (NUM_SRC),
      .GRP_W       (GRP_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_all (srst),
      .wr_en   (bus_we && !blocked),
      .grp     (grp),
      .al      (al),
      .wdata   (bus_wdata[2:0]),
      .src_i   (src_i),
      .cfg_o   (cfg),
      .en_o    (en_vec),
      .pend_o  (pend)
   );

   ic_pick #(.N(NUM_SRC), .ID_W(ID_W)) u_pick (
      .req   (pend),
      .found (live_found),
      .id    (live_id)
   );

   ic_service #(.ID_W(ID_W)) u_svc (
      .clk        (clk),
      .rst_n      (rst_n),
      .hold_clr   (srst),
      .blocked    (blocked),
      .take_ev    (take_ev),
      .ack_ev     (ack_ev),
      .live_found (live_found),
      .live_id    (live_id),
      .taken_o    (taken),
      .status_o   (status),
      .irq_o      (irq_o)
   );

   always_comb begin
      bus_rdata = '0;
      if (grp == GRP_W'(GRP_CTRL))
         bus_rdata = {ctrl_q, 30'b0};
      else if (grp == GRP_W'(GRP_STAT))
         bus_rdata = {{(32-ID_W){1'b0}}, status};
      else if (grp >= GRP_W'(GRP_SRC0) && rel < GRP_W'(NUM_SRC))
         bus_rdata = {29'b0, cfg[rel[ID_W-1:0]]};
   end
endmodule

// File: rtl/ic_collector_chk.sv
module ic_collector_chk #(
   parameter int NUM_SRC = 128,
   parameter int ID_W    = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               irq_o,
   input logic               blocked,
   input logic               srst,
   input logic               taken,
   input logic               take_ev,
   input logic               ack_ev,
   input logic [ID_W-1:0]    status,
   input logic [NUM_SRC-1:0] en,
   input logic [NUM_SRC-1:0] pend
);
   localparam logic [ID_W-1:0] NONE = '1;

   p_stall_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      blocked |-> !irq_o);

   p_srst_wipes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (en == '0));

   p_pending_raises_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!blocked && !taken && (pend != '0)) |-> irq_o);

   p_winner_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> pend[status]);

   p_empty_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!taken && pend == '0) |-> (!irq_o && status == NONE));

   p_taken_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      taken |-> !irq_o);

   p_take_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!taken && !blocked && take_ev) |=> taken);

   p_frozen_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && !blocked && !ack_ev) |=> (blocked || $stable(status)));

   p_ack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && !blocked && ack_ev) |=> !taken);
endmodule

bind ic_collector ic_collector_chk #(
   .NUM_SRC (NUM_SRC),
   .ID_W    (ID_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .irq_o   (irq_o),
   .blocked (blocked),
   .srst    (srst),
   .taken   (taken),
   .take_ev (take_ev),
   .ack_ev  (ack_ev),
   .status  (status),
   .en      (en_vec),
   .pend    (pend)
);

// File: tb/sim_ic_collector.sv
module sim_ic_collector;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [127:0] src = '0;
   logic         we = 1'b0;
   logic [11:0]  addr = '0;
   logic [31:0]  wd = '0;
   logic [31:0]  rd;
   logic         irq;

   always #4 clk = ~clk;

   ic_collector u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src),
      .bus_we    (we),
      .bus_addr  (addr),
      .bus_wdata (wd),
      .bus_rdata (rd),
      .irq_o     (irq)
   );

   // behavioural reference
   bit       m_en [128];
   bit [1:0] m_pr [128];
   bit       m_srst, m_gate, m_taken;
   int       m_frozen;
   string    cur_req = "R1";
   int       n_chk = 0, n_fail = 0;

   function automatic int live_id();
      for (int i = 0; i < 128; i++) if (src[i] && m_en[i]) return i;
      return -1;
   endfunction

   function automatic logic [31:0] alias_apply(int al, logic [31:0] c, logic [31:0] w);
      case (al)
         0: return w;
         1: return c | w;
         2: return c & ~w;
         default: return c ^ w;
      endcase
   endfunction

   function automatic bit m_blk();
      return m_srst || m_gate;
   endfunction

   function automatic logic exp_irq();
      return !m_blk() && !m_taken && live_id() >= 0;
   endfunction

   function automatic int exp_status();
      if (m_blk()) return 127;
      if (m_taken) return m_frozen;
      return (live_id() < 0) ? 127 : live_id();
   endfunction

   function automatic logic [31:0] exp_rdata();
      int g = int'(addr) / 16;
      if (g == 2) return {m_srst, m_gate, 30'b0};
      if (g == 7) return exp_status();
      if (g >= 18 && g < 146) return {29'b0, m_en[g-18], m_pr[g-18]};
      return 32'h0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 128; i++) begin m_en[i] = 0; m_pr[i] = 0; end
         m_srst = 1; m_gate = 1; m_taken = 0; m_frozen = 127;
      end else begin
         int g, al, live;
         bit blk;
         logic [31:0] v;
         g = int'(addr) / 16; al = int'(addr[3:2]); blk = m_blk(); live = live_id();
         if (m_srst) begin
            m_taken = 0; m_frozen = 127;
            for (int i = 0; i < 128; i++) begin m_en[i] = 0; m_pr[i] = 0; end
         end else if (!blk && we) begin
            if (g == 0 && !m_taken) begin
               m_taken = 1; m_frozen = (live < 0) ? 127 : live;
            end else if (g == 1 && m_taken && wd[0]) m_taken = 0;
            if (g >= 18 && g < 146) begin
               v = alias_apply(al, {29'b0, m_en[g-18], m_pr[g-18]}, wd);
               m_en[g-18] = v[2]; m_pr[g-18] = v[1:0];
            end
         end
         if (we && g == 2) begin
            v = alias_apply(al, {m_srst, m_gate, 30'b0}, wd);
            m_srst = v[31]; m_gate = v[30];
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         n_chk += 2;
         if (irq !== exp_irq()) begin
            n_fail++;
            $display("FAIL %s irq actual %0b expected %0b at %0t", cur_req, irq, exp_irq(), $time);
         end
         if (rd !== exp_rdata()) begin
            n_fail++;
            $display("FAIL %s rdata @%h actual %h expected %h at %0t", cur_req, addr, rd, exp_rdata(), $time);
         end
      end
   end

   task automatic step(int n = 1);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      we = 1; addr = a; wd = d;
      step();
      we = 0;
   endtask

   task automatic look(logic [11:0] a);
      addr = a;
      step();
   endtask

   bit done = 0;

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1;
      cur_req = "R1";
      look(12'h020); look(12'h120); look(12'h910); look(12'h070);
      // R2: stalled block ignores source, vector writes
      cur_req = "R2";
      src[5] = 1;
      wr(12'h170, 32'h4); look(12'h170);
      wr(12'h000, 32'h0); look(12'h070);
      // R3: clear alias on control releases the block
      cur_req = "R3";
      wr(12'h028, 32'h4000_0000); look(12'h020);
      wr(12'h028, 32'h8000_0000); look(12'h024);
      wr(12'h150, 32'hFFFF_FFFF); look(12'h150);
      wr(12'h158, 32'h0000_0004); look(12'h154);
      wr(12'h15C, 32'h0000_0005); look(12'h158);
      wr(12'h154, 32'h0000_0001); look(12'h15C);
      // R4: other bits read 0, priority stored
      cur_req = "R4";
      wr(12'h3A0, 32'hFFFF_FFF4); look(12'h3A0);
      wr(12'h1C0, 32'h4); wr(12'h910, 32'h4);
      // R5 / R6: lowest pending enabled wins
      cur_req = "R6";
      look(12'h070);
      src[40] = 1; step();
      src[10] = 1; step();
      cur_req = "R5";
      src[2] = 1; step();
      src[3] = 1; step();
      src[3] = 0; step();
      // R8: take freezes status
      cur_req = "R8";
      wr(12'h004, 32'h0); look(12'h070);
      src[10] = 0; step(2);
      // R9: ack with bit0 clear ignored, set releases
      cur_req = "R9";
      wr(12'h010, 32'h0); look(12'h070);
      wr(12'h010, 32'h1); look(12'h070);
      // R10: still-high source comes back
      cur_req = "R10";
      wr(12'h000, 32'h0); step();
      wr(12'h01C, 32'h1); step(2);
      // R4: priority field has no effect on selection
      cur_req = "R4";
      wr(12'h3A4, 32'h3); look(12'h070);
      // R11: status write ignored, event registers read 0
      cur_req = "R11";
      wr(12'h070, 32'h5); look(12'h070);
      look(12'h000); look(12'h010);
      // R7: nothing pending, then source 127 alone
      cur_req = "R7";
      src = '0; look(12'h070);
      src[127] = 1; step(2);
      // R2: soft reset while taken wipes everything
      cur_req = "R2";
      wr(12'h000, 32'h0);
      wr(12'h024, 32'h8000_0000); step(2);
      wr(12'h028, 32'h8000_0000);
      look(12'h910); look(12'h3A0); look(12'h070);
      step(2);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule